// File: doc/BRIEF.md
# Local Bus Chip-Select Decoder

This block turns a host access into the address and select signals of an 8-bit peripheral bus. The host side presents a byte address, a flag that tells an I/O-space access from a memory-space access, a direction bit and a valid strobe. The peripheral side gets eight address lines, four active-low select lines and the cycle-type lines. Two static settings shape I/O decoding: the I/O window size and the lowest address bit of the two-bit field that picks a select. Depending on these settings, an I/O window splits into one, two or four select regions. Memory accesses use a fixed map of 1 KB regions with DWORD addressing and ignore both settings.

A mode input picks how the select lines are used. In chip-select mode they act as chip selects, with separate active-low read and write strobes. In data-strobe mode the same lines act as data strobes, paired with a single read/not-write line. All outputs come from registers. A three-state controller (`ST_IDLE`, `ST_ACTIVE`, `ST_RELEASE`) captures an access on the first edge where the valid strobe is seen. It holds the outputs steady while the strobe stays high, then releases the bus. Transitions: `ST_IDLE`→`ST_ACTIVE` when valid is high; `ST_ACTIVE`→`ST_ACTIVE` while valid stays high; `ST_ACTIVE`→`ST_RELEASE` when valid drops; `ST_RELEASE`→`ST_IDLE` always, whatever valid is.

Top module: `lbus_sel_decoder`

## Requirements
- R1: While reset is asserted and right after it, `lb_addr` is 0, all four `lb_sel_n` bits are 1, and `lb_rd_n`, `lb_wr_n` and `lb_rnw` are 1.
- R2: In `ST_IDLE`, a rising edge with `acc_valid` high loads all outputs from the access presented at that edge. While `acc_valid` stays high, the outputs hold and later changes on the access and mode inputs have no effect.
- R3: The first edge with `acc_valid` low in `ST_ACTIVE` drives all selects and both strobes high and sets `lb_rnw` to 1, keeping `lb_addr`. The edge after that ignores `acc_valid`, so a new access shows its selects no earlier than two edges after the release.
- R4: At most one `lb_sel_n` bit is 0 at any time, and none is 0 outside `ST_ACTIVE`.
- R5: The effective I/O window size is the largest power of two not above `cfg_io_size` (9 bits), limited to the range 4 to 256 bytes. Values 0 to 3 give 4, and values 256 to 511 give 256.
- R6: For an I/O access, `lb_addr` equals `acc_addr[7:0]` with every bit at or above log2(window size) forced to 0. With a 256-byte window it equals `acc_addr[7:0]` unchanged.
- R7: For an I/O access, the select index is bits [N+1:N] of the masked address, where N is `cfg_cs_lsb` and values above 8 count as 8. Index k drives `lb_sel_n[k]` low. Example: a 32-byte window with N=3 gives index 0 for offsets 00-07h, 1 for 08-0Fh, 2 for 10-17h and 3 for 18-1Fh.
- R8: When N is the top bit of the I/O window, only `lb_sel_n[0]` and `lb_sel_n[1]` can assert, each covering half of the window. When N is above the window, only `lb_sel_n[0]` asserts, for the whole window.
- R9: For a memory access (`acc_is_mem`=1), `lb_addr` = `acc_addr[9:2]` and the select index = `acc_addr[11:10]`. Index 0 covers 000h-3FFh, 1 covers 400h-7FFh, 2 covers 800h-BFFh and 3 covers C00h-FFFh. `cfg_io_size` and `cfg_cs_lsb` have no effect.
- R10: With `cfg_strobe_mode`=0, `lb_rd_n` is 0 during a read (`acc_wr`=0) and `lb_wr_n` is 0 during a write (`acc_wr`=1). The other strobe stays 1 and `lb_rnw` stays 1.
- R11: With `cfg_strobe_mode`=1, the selects decode exactly as in R6 to R9 and `lb_addr` is the same. `lb_rd_n` and `lb_wr_n` stay 1, and `lb_rnw` is 1 for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access in progress; held high until the access completes |
| acc_is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Host byte address offset |
| cfg_io_size | input | 9 | I/O window size in bytes (clamped) |
| cfg_cs_lsb | input | 4 | Lowest bit of the I/O select field (clamped to 8) |
| cfg_strobe_mode | input | 1 | 0 = chip selects with read/write strobes, 1 = data strobes with R/W line |
| lb_addr | output | 8 | Peripheral bus address |
| lb_sel_n | output | 4 | Active-low chip selects or data strobes |
| lb_rd_n | output | 1 | Active-low read strobe (chip-select mode) |
| lb_wr_n | output | 1 | Active-low write strobe (chip-select mode) |
| lb_rnw | output | 1 | Read/not-write line (data-strobe mode) |

## Verification
A controller stuck in or skipping a state shows at the ports within one or two edges. A select stays low after `acc_valid` drops, a release is missed, or a new access appears one edge too early after a release. A wrong mask or a wrong bit-pair pick inside the I/O path shows on the first access: an upper address line is set, or the wrong select goes low. A memory map that reused the I/O settings would be exposed by the rows that program a small window together with a memory access.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RELEASE = 2'd2
    } lbsel_state_t;

    typedef enum logic {
        MODE_CHIPSEL = 1'b0,
        MODE_DSTROBE = 1'b1
    } lbsel_mode_t;

endpackage

// File: rtl/lbsel_io_map.sv
module lbsel_io_map #(
    parameter int LB_AW    = 8,
    parameter int IDX_W    = 2,
    parameter int LSB_W    = 4,
    parameter int MIN_LOG2 = 2
) (
    input  logic [LB_AW-1:0] host_addr,
    input  logic [LB_AW:0]   cfg_io_size,
    input  logic [LSB_W-1:0] cfg_cs_lsb,
    output logic [LB_AW-1:0] io_addr,
    output logic [LB_AW-1:0] io_mask,
    output logic [IDX_W-1:0] io_idx
);
    localparam int LOG2_W = $clog2(LB_AW + 1);
    localparam int EXT_W  = LB_AW + IDX_W;

    logic [LOG2_W-1:0] size_log2;
    logic [LB_AW:0]    wide_mask;
    logic [LSB_W-1:0]  lsb_eff;
    logic [EXT_W-1:0]  ext_addr;
    logic [EXT_W-1:0]  shifted;

    // Largest set bit at or above the minimum decides the window (R5)
    always_comb begin
        size_log2 = LOG2_W'(MIN_LOG2);
        for (int b = MIN_LOG2; b <= LB_AW; b++) begin
            if (cfg_io_size[b]) begin
                size_log2 = LOG2_W'(b);
            end
        end
    end

    always_comb begin
        wide_mask = ((LB_AW + 1)'(1) << size_log2) - (LB_AW + 1)'(1);
        io_mask   = wide_mask[LB_AW-1:0];
        io_addr   = host_addr & io_mask;
    end

    // Bit pair selection with upper clamp of the low decode bit (R7)
    always_comb begin
        if (cfg_cs_lsb > LSB_W'(LB_AW)) begin
            lsb_eff = LSB_W'(LB_AW);
        end else begin
            lsb_eff = cfg_cs_lsb;
        end
        ext_addr = {{IDX_W{1'b0}}, io_addr};
        shifted  = ext_addr >> lsb_eff;
        io_idx   = shifted[IDX_W-1:0];
    end

endmodule

// File: rtl/lbsel_mem_map.sv
module lbsel_mem_map #(
    parameter int LB_AW   = 8,
    parameter int IDX_W   = 2,
    parameter int HOST_AW = LB_AW + IDX_W + 2
) (
    input  logic [HOST_AW-1:0] host_addr,
    output logic [LB_AW-1:0]   mem_addr,
    output logic [IDX_W-1:0]   mem_idx
);
    localparam int WORD_SHIFT = 2;
    localparam int IDX_LO     = LB_AW + WORD_SHIFT;

    // DWORD-granular map: low two bits dropped, regions above the local lines
    always_comb begin
        mem_addr = host_addr[LB_AW+WORD_SHIFT-1:WORD_SHIFT];
        mem_idx  = host_addr[IDX_LO+IDX_W-1:IDX_LO];
    end

endmodule

// File: rtl/lbsel_sel_decode.sv
module lbsel_sel_decode #(
    parameter int IDX_W   = 2,
    parameter int NUM_SEL = 1 << IDX_W
) (
    input  logic               enable,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SEL-1:0] sel_n
);
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_n[g] = !(enable && (idx == IDX_W'(g)));
    end

endmodule

// File: rtl/lbus_sel_decoder.sv
module lbus_sel_decoder #(
    parameter int LB_AW = 8,
    parameter int IDX_W = 2,
    parameter int LSB_W = 4,
    localparam int NUM_SEL = 1 << IDX_W,
    localparam int HOST_AW = LB_AW + IDX_W + 2,
    localparam int SZ_W    = LB_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_is_mem,
    input  logic               acc_wr,
    input  logic [HOST_AW-1:0] acc_addr,
    input  logic [SZ_W-1:0]    cfg_io_size,
    input  logic [LSB_W-1:0]   cfg_cs_lsb,
    input  logic               cfg_strobe_mode,
    output logic [LB_AW-1:0]   lb_addr,
    output logic [NUM_SEL-1:0] lb_sel_n,
    output logic               lb_rd_n,
    output logic               lb_wr_n,
    output logic               lb_rnw
);
    import lbsel_pkg::*;

    lbsel_state_t state_q, state_d;

    logic [LB_AW-1:0]   io_addr, io_mask, mem_addr, next_addr;
    logic [IDX_W-1:0]   io_idx, mem_idx, next_idx;
    logic [NUM_SEL-1:0] next_sel_n;
    lbsel_mode_t        mode;

    assign mode = lbsel_mode_t'(cfg_strobe_mode);

    lbsel_io_map #(
        .LB_AW (LB_AW),
        .IDX_W (IDX_W),
        .LSB_W (LSB_W)
    ) io_map_i (
        .host_addr   (acc_addr[LB_AW-1:0]),
        .cfg_io_size (cfg_io_size),
        .cfg_cs_lsb  (cfg_cs_lsb),
        .io_addr     (io_addr),
        .io_mask     (io_mask),
        .io_idx      (io_idx)
    );

    lbsel_mem_map #(
        .LB_AW (LB_AW),
        .IDX_W (IDX_W)
    ) mem_map_i (
        .host_addr (acc_addr),
        .mem_addr  (mem_addr),
        .mem_idx   (mem_idx)
    );

    assign next_addr = acc_is_mem ? mem_addr : io_addr;
    assign next_idx  = acc_is_mem ? mem_idx  : io_idx;

    lbsel_sel_decode #(
        .IDX_W (IDX_W)
    ) sel_dec_i (
        .enable (1'b1),
        .idx    (next_idx),
        .sel_n  (next_sel_n)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (acc_valid)  state_d = ST_ACTIVE;
            ST_ACTIVE:  if (!acc_valid) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lb_addr  <= '0;
            lb_sel_n <= '1;
            lb_rd_n  <= 1'b1;
            lb_wr_n  <= 1'b1;
            lb_rnw   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        lb_addr  <= next_addr;
                        lb_sel_n <= next_sel_n;
                        lb_rd_n  <= !((mode == MODE_CHIPSEL) && !acc_wr);
                        lb_wr_n  <= !((mode == MODE_CHIPSEL) && acc_wr);
                        lb_rnw   <= (mode == MODE_DSTROBE) ? !acc_wr : 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (!acc_valid) begin
                        lb_sel_n <= '1;
                        lb_rd_n  <= 1'b1;
                        lb_wr_n  <= 1'b1;
                        lb_rnw   <= 1'b1;
                    end
                end
                ST_RELEASE: begin
                    lb_sel_n <= '1;
                    lb_rd_n  <= 1'b1;
                    lb_wr_n  <= 1'b1;
                    lb_rnw   <= 1'b1;
                end
                default: begin
                    lb_sel_n <= '1;
                end
            endcase
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && acc_valid) |=> ($stable(lb_addr) && $stable(lb_sel_n))); // R2

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE) |=> (state_q == ST_IDLE && (&lb_sel_n))); // R3

    AST_SEL_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~lb_sel_n) <= 1); // R4

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE) |-> (&lb_sel_n)); // R4

    AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && acc_valid && !acc_is_mem)
        |=> ((lb_addr & ~$past(io_mask)) == '0)); // R6

    AST_MEM_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && acc_valid && acc_is_mem)
        |=> (lb_addr == $past(acc_addr[LB_AW+1:2]))); // R9

    AST_DSTROBE_NO_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && acc_valid && cfg_strobe_mode)
        |=> (lb_rd_n && lb_wr_n)); // R11

endmodule

// File: tb/lbus_sel_decoder_tb_top.sv
module lbus_sel_decoder_tb_top;

    typedef struct packed {
        logic        is_mem;
        logic        wr;
        logic        mode;
        logic [11:0] addr;
        logic [8:0]  size;
        logic [3:0]  lsb;
        logic [7:0]  e_addr;
        logic [3:0]  e_sel;
        logic        e_rd_n;
        logic        e_wr_n;
        logic        e_rnw;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b0,12'h005,9'd32, 4'd3, 8'h05,4'b1110,1'b0,1'b1,1'b1,8'd7},  // R7 CS0
        '{1'b0,1'b1,1'b0,12'h00A,9'd32, 4'd3, 8'h0A,4'b1101,1'b1,1'b0,1'b1,8'd10}, // R10 write, CS1
        '{1'b0,1'b0,1'b0,12'h013,9'd32, 4'd3, 8'h13,4'b1011,1'b0,1'b1,1'b1,8'd7},  // R7 CS2
        '{1'b0,1'b0,1'b0,12'h01F,9'd32, 4'd3, 8'h1F,4'b0111,1'b0,1'b1,1'b1,8'd7},  // R7 CS3
        '{1'b0,1'b0,1'b0,12'hFE5,9'd32, 4'd3, 8'h05,4'b1110,1'b0,1'b1,1'b1,8'd6},  // R6 upper masked
        '{1'b0,1'b0,1'b0,12'h01C,9'd32, 4'd4, 8'h1C,4'b1101,1'b0,1'b1,1'b1,8'd8},  // R8 two regions
        '{1'b0,1'b1,1'b0,12'h0F3,9'd32, 4'd4, 8'h13,4'b1101,1'b1,1'b0,1'b1,8'd8},  // R8 two regions
        '{1'b0,1'b0,1'b0,12'h01F,9'd32, 4'd5, 8'h1F,4'b1110,1'b0,1'b1,1'b1,8'd8},  // R8 one region
        '{1'b0,1'b0,1'b0,12'h3C7,9'd256,4'd6, 8'hC7,4'b0111,1'b0,1'b1,1'b1,8'd6},  // R6 full window
        '{1'b0,1'b0,1'b0,12'h0FE,9'd4,  4'd0, 8'h02,4'b1011,1'b0,1'b1,1'b1,8'd6},  // R6 smallest window
        '{1'b0,1'b0,1'b0,12'h03B,9'd48, 4'd3, 8'h1B,4'b0111,1'b0,1'b1,1'b1,8'd5},  // R5 48 -> 32
        '{1'b0,1'b0,1'b0,12'h0FF,9'd1,  4'd2, 8'h03,4'b1110,1'b0,1'b1,1'b1,8'd5},  // R5 1 -> 4
        '{1'b0,1'b0,1'b0,12'h0AB,9'd511,4'd12,8'hAB,4'b1110,1'b0,1'b1,1'b1,8'd5},  // R5 511 -> 256, R7 lsb 12 -> 8
        '{1'b1,1'b0,1'b0,12'h000,9'd4,  4'd0, 8'h00,4'b1110,1'b0,1'b1,1'b1,8'd9},  // R9 region 0
        '{1'b1,1'b0,1'b0,12'h7FC,9'd4,  4'd0, 8'hFF,4'b1101,1'b0,1'b1,1'b1,8'd9},  // R9 region 1 top
        '{1'b1,1'b1,1'b0,12'h808,9'd32, 4'd3, 8'h02,4'b1011,1'b1,1'b0,1'b1,8'd9},  // R9 region 2 write
        '{1'b1,1'b0,1'b1,12'hC10,9'd32, 4'd3, 8'h04,4'b0111,1'b1,1'b1,1'b1,8'd11}, // R11 mem read
        '{1'b0,1'b1,1'b1,12'h00A,9'd32, 4'd3, 8'h0A,4'b1101,1'b1,1'b1,1'b0,8'd11}, // R11 io write
        '{1'b1,1'b0,1'b0,12'h403,9'd256,4'd7, 8'h00,4'b1101,1'b0,1'b1,1'b1,8'd9}   // R9 settings ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_mem = 1'b0;
    logic        acc_wr = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [8:0]  cfg_io_size = 9'd32;
    logic [3:0]  cfg_cs_lsb = 4'd3;
    logic        cfg_strobe_mode = 1'b0;
    logic [7:0]  lb_addr;
    logic [3:0]  lb_sel_n;
    logic        lb_rd_n, lb_wr_n, lb_rnw;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    lbus_sel_decoder dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_valid       (acc_valid),
        .acc_is_mem      (acc_is_mem),
        .acc_wr          (acc_wr),
        .acc_addr        (acc_addr),
        .cfg_io_size     (cfg_io_size),
        .cfg_cs_lsb      (cfg_cs_lsb),
        .cfg_strobe_mode (cfg_strobe_mode),
        .lb_addr         (lb_addr),
        .lb_sel_n        (lb_sel_n),
        .lb_rd_n         (lb_rd_n),
        .lb_wr_n         (lb_wr_n),
        .lb_rnw          (lb_rnw)
    );

    function automatic logic [14:0] outs();
        return {lb_addr, lb_sel_n, lb_rd_n, lb_wr_n, lb_rnw};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 32'(outs()), 32'({8'h00, 4'b1111, 3'b111}));
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 after reset", 32'(outs()), 32'({8'h00, 4'b1111, 3'b111}));

        for (int i = 0; i < NVEC; i++) begin
            acc_is_mem      = VECS[i].is_mem;
            acc_wr          = VECS[i].wr;
            acc_addr        = VECS[i].addr;
            cfg_io_size     = VECS[i].size;
            cfg_cs_lsb      = VECS[i].lsb;
            cfg_strobe_mode = VECS[i].mode;
            acc_valid       = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), 32'(outs()),
                32'({VECS[i].e_addr, VECS[i].e_sel, VECS[i].e_rd_n, VECS[i].e_wr_n, VECS[i].e_rnw}));
            chk($sformatf("R4 one select, vector %0d", i), 32'($countones(~lb_sel_n)), 32'd1);
            acc_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R4 released, vector %0d", i), 32'(lb_sel_n), 32'hF);
            @(posedge clk);
            @(negedge clk);
        end

        // R2: access held, input changes ignored
        acc_is_mem = 1'b0; acc_wr = 1'b0; acc_addr = 12'h013;
        cfg_io_size = 9'd32; cfg_cs_lsb = 4'd3; cfg_strobe_mode = 1'b0;
        acc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 capture", 32'(outs()), 32'({8'h13, 4'b1011, 3'b011}));
        acc_addr = 12'h01F; acc_wr = 1'b1; cfg_strobe_mode = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 held", 32'(outs()), 32'({8'h13, 4'b1011, 3'b011}));

        // R3: release then ignored re-request
        acc_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 release", 32'(outs()), 32'({8'h13, 4'b1111, 3'b111}));
        acc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R3 gap edge ignores valid", 32'(outs()), 32'({8'h13, 4'b1111, 3'b111}));
        @(posedge clk);
        @(negedge clk);
        chk("R3 next access after gap", 32'(outs()), 32'({8'h1F, 4'b0111, 3'b110}));
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 idle after final release", 32'(lb_sel_n), 32'hF);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule